// File: doc/BRIEF.md
# Four-Channel DAC Serial Register Front End

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. An SPI-compatible host drives a frame-select line (active low), a serial clock and a data input. The block oversamples all three in the system clock domain, assembles 16-bit frames and decodes them. Writes go to four channel input registers, and the host can read registers back on a serial data output whose drive is exposed as an enable.

Each channel has two registers. The input register holds pending data, and the output-stage register holds the code actually presented to the converter. A load strobe (active low) moves all pending data across on its falling edge. If the strobe is held low when a write executes, the addressed channel updates at once. A clear input (active low) zeroes every register on its falling edge and, while it stays low, blocks the load strobe. Writes to the control address are not stored here: they leave as a one-cycle strobe with 12 data bits for a separate control block, whose contents come back in on a read port.

Top module: `quad_dac_serial_if`

## Requirements
- R1: A frame is 16 bits, MSB first: bit 15 read(1)/write(0), bits 14:12 address, bits 11:0 data. A write to address 1, 2, 3 or 4 loads the input register of channel 0, 1, 2 or 3 when the 16th falling serial clock edge executes it. With the load strobe high, the channel output codes do not change.
- R2: If frame select rises before the 16th falling serial clock edge, the frame has no effect, even when all 16 rising edges were seen.
- R3: A write to address 5 loads the same data into all four input registers.
- R4: A write to address 0 or address 6 changes no register and produces no control strobe.
- R5: A write to address 7 raises ctrl_wr_o for exactly one system clock, with ctrl_wdata_o equal to the 12 data bits.
- R6: A falling edge of the load strobe copies all four input registers into the output codes together.
- R7: If the load strobe is low when a write executes, each addressed channel's output code takes the new data in the same update.
- R8: A falling edge of the clear input sets all input registers and output codes to 0. While clear stays low, load strobe edges have no effect, although input registers can still be written.
- R9: In a read frame, sdo_en_o stays low through the first four rising serial clock edges. From the fifth rising edge, 12 bits are shifted out MSB first, one per rising edge, and sdo_en_o returns low at the 16th falling edge or when frame select rises.
- R10: A read of address 1 to 4 returns that channel's input register, and a read of address 7 returns ctrl_rdata_i. A read of address 0, 5 or 6 returns 0. A read changes no register.
- R11: After reset, all output codes are 0, sdo_en_o is low and ctrl_wr_o is low.
- R12: The output codes change only on an executed write, a load strobe falling edge or a clear falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Load strobe, active low |
| clr_n_i | input | 1 | Clear, falling-edge active |
| ctrl_rdata_i | input | 12 | Current contents of the external control register |
| sdo_o | output | 1 | Serial data out, valid while sdo_en_o is high |
| sdo_en_o | output | 1 | Output drive enable (high-impedance when low) |
| dac_codes_o | output | 48 | Output codes, channel n in bits 12n+11:12n |
| ctrl_wr_o | output | 1 | One-cycle control write strobe |
| ctrl_wdata_o | output | 12 | Control write data |

## Verification
The hardest case to reach from the ports is a frame that has delivered all 16 rising serial clock edges and is then aborted by frame select rising before the final falling edge. It holds a complete, valid word that must still be thrown away. The stimulus stops its bit loop with the clock high and raises frame select, then reads the target register back. A second difficult case is a load strobe pulse while clear is held low after fresh input writes. The bench writes during the clear, pulses the strobe, and only then releases clear. Random frames mix the load strobe level, clear pulses and all eight addresses.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    localparam int CODE_W  = 12;
    localparam int ADDR_W  = 3;
    localparam int HDR_W   = 1 + ADDR_W;
    localparam int FRAME_W = HDR_W + CODE_W;
    localparam int NUM_CH  = 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_NONE  = 3'd0,
        SEL_CH0   = 3'd1,
        SEL_CH1   = 3'd2,
        SEL_CH2   = 3'd3,
        SEL_CH3   = 3'd4,
        SEL_BCAST = 3'd5,
        SEL_SPARE = 3'd6,
        SEL_CTRL  = 3'd7
    } sel_e;

    typedef struct packed {
        logic  rd;
        sel_e  sel;
        code_t data;
    } frame_t;

    // True when a write with this selector targets channel ch.
    function automatic logic sel_hits_ch(sel_e s, int ch);
        return (s == SEL_BCAST) || (int'(s) == ch + 1);
    endfunction

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int             N       = 5,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
        end
        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import dac_if_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_rise,
    input  logic   sclk_fall,
    input  logic   sync_fall,
    input  logic   sync_rise,
    input  logic   sdi,
    output logic   exec_o,
    output frame_t frame_o,
    output logic   tx_start_o,
    output sel_e   tx_sel_o,
    output logic   tx_shift_o,
    output logic   tx_stop_o
);

    localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_M1 = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] HDR     = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic               active_q;
    logic [CNT_W-1:0]   rise_cnt_q;
    logic [CNT_W-1:0]   fall_cnt_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               final_fall;

    assign final_fall = active_q && sclk_fall && (fall_cnt_q == LAST_M1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            rise_cnt_q <= '0;
            fall_cnt_q <= '0;
            shreg_q    <= '0;
            exec_o     <= 1'b0;
            frame_o    <= '0;
        end else begin
            exec_o <= 1'b0;
            if (sync_fall) begin
                active_q   <= 1'b1;
                rise_cnt_q <= '0;
                fall_cnt_q <= '0;
            end else if (sync_rise) begin
                active_q <= 1'b0;
            end else if (active_q) begin
                if (sclk_rise && (rise_cnt_q != LAST)) begin
                    shreg_q    <= {shreg_q[FRAME_W-2:0], sdi};
                    rise_cnt_q <= rise_cnt_q + ONE;
                end
                if (sclk_fall) begin
                    fall_cnt_q <= fall_cnt_q + ONE;
                    if (final_fall) begin
                        active_q <= 1'b0;
                        exec_o   <= (rise_cnt_q == LAST);
                        frame_o  <= frame_t'(shreg_q);
                    end
                end
            end
        end
    end

    // Header is complete after four rising edges; the fifth starts readback.
    assign tx_start_o = active_q && sclk_rise && (rise_cnt_q == HDR) && shreg_q[HDR_W-1];
    assign tx_sel_o   = sel_e'(shreg_q[ADDR_W-1:0]);
    assign tx_shift_o = active_q && sclk_rise && (rise_cnt_q > HDR) && (rise_cnt_q != LAST);
    assign tx_stop_o  = sync_fall || sync_rise || final_fall;

endmodule

// File: rtl/dac_sdo_tx.sv
module dac_sdo_tx
    import dac_if_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  shift_i,
    input  logic  stop_i,
    input  code_t load_i,
    output logic  sdo_o,
    output logic  sdo_en_o
);

    code_t sh_q;
    logic  en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            en_q <= 1'b0;
        end else if (stop_i) begin
            en_q <= 1'b0;
        end else if (start_i) begin
            sh_q <= load_i;
            en_q <= 1'b1;
        end else if (shift_i && en_q) begin
            sh_q <= {sh_q[CODE_W-2:0], 1'b0};
        end
    end

    assign sdo_o    = en_q & sh_q[CODE_W-1];
    assign sdo_en_o = en_q;

endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
    import dac_if_pkg::*;
#(
    parameter int NUM = NUM_CH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                exec_i,
    input  frame_t              frame_i,
    input  logic                ldac_n_lvl,
    input  logic                ldac_fall,
    input  logic                clr_n_lvl,
    input  logic                clr_fall,
    input  sel_e                rd_sel_i,
    input  code_t               ctrl_rdata_i,
    output code_t               rd_data_o,
    output logic [NUM*CODE_W-1:0] dac_codes_o,
    output logic                ctrl_wr_o,
    output code_t               ctrl_wdata_o
);

    logic [NUM*CODE_W-1:0] in_flat;
    logic                  wr_cmd;

    assign wr_cmd = exec_i && !frame_i.rd;

    for (genvar ch = 0; ch < NUM; ch++) begin : g_ch
        code_t in_q;
        code_t dac_q;
        logic  hit;

        assign hit = wr_cmd && sel_hits_ch(frame_i.sel, ch);

        always_ff @(posedge clk) begin
            if (rst || clr_fall) begin
                in_q  <= '0;
                dac_q <= '0;
            end else begin
                if (hit) begin
                    in_q <= frame_i.data;
                end
                if (hit && !ldac_n_lvl) begin
                    dac_q <= frame_i.data;
                end else if (ldac_fall && clr_n_lvl) begin
                    dac_q <= in_q;
                end
            end
        end

        assign in_flat[ch*CODE_W +: CODE_W]     = in_q;
        assign dac_codes_o[ch*CODE_W +: CODE_W] = dac_q;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i == SEL_CTRL) begin
            rd_data_o = ctrl_rdata_i;
        end else begin
            for (int c = 0; c < NUM; c++) begin
                if (int'(rd_sel_i) == c + 1) begin
                    rd_data_o = in_flat[c*CODE_W +: CODE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_wr_o    <= 1'b0;
            ctrl_wdata_o <= '0;
        end else begin
            ctrl_wr_o <= wr_cmd && (frame_i.sel == SEL_CTRL);
            if (wr_cmd && (frame_i.sel == SEL_CTRL)) begin
                ctrl_wdata_o <= frame_i.data;
            end
        end
    end

endmodule

// File: rtl/quad_dac_serial_if.sv
module quad_dac_serial_if
    import dac_if_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sync_n_i,
    input  logic                     sclk_i,
    input  logic                     sdi_i,
    input  logic                     ldac_n_i,
    input  logic                     clr_n_i,
    input  logic [CODE_W-1:0]        ctrl_rdata_i,
    output logic                     sdo_o,
    output logic                     sdo_en_o,
    output logic [NUM_CH*CODE_W-1:0] dac_codes_o,
    output logic                     ctrl_wr_o,
    output logic [CODE_W-1:0]        ctrl_wdata_o
);

    // Synchronised pins: [0] sclk, [1] sdi, [2] sync_n, [3] ldac_n, [4] clr_n
    localparam int           NPIN    = 5;
    localparam logic [NPIN-1:0] PIN_RST = 5'b11100;

    logic [NPIN-1:0] pin_lvl;
    logic            sclk_prev_q, sync_prev_q, ldac_prev_q, clr_prev_q;
    logic            sclk_rise, sclk_fall, sync_rise, sync_fall;
    logic            ldac_fall_w, clr_fall_w, sync_lvl_w;
    logic            exec_w;
    frame_t          frame_w;
    logic            tx_start, tx_shift, tx_stop;
    sel_e            tx_sel;
    code_t           rd_data;

    dac_in_sync #(
        .N       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({clr_n_i, ldac_n_i, sync_n_i, sdi_i, sclk_i}),
        .q_o (pin_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= PIN_RST[0];
            sync_prev_q <= PIN_RST[2];
            ldac_prev_q <= PIN_RST[3];
            clr_prev_q  <= PIN_RST[4];
        end else begin
            sclk_prev_q <= pin_lvl[0];
            sync_prev_q <= pin_lvl[2];
            ldac_prev_q <= pin_lvl[3];
            clr_prev_q  <= pin_lvl[4];
        end
    end

    assign sclk_rise   =  pin_lvl[0] & ~sclk_prev_q;
    assign sclk_fall   = ~pin_lvl[0] &  sclk_prev_q;
    assign sync_rise   =  pin_lvl[2] & ~sync_prev_q;
    assign sync_fall   = ~pin_lvl[2] &  sync_prev_q;
    assign ldac_fall_w = ~pin_lvl[3] &  ldac_prev_q;
    assign clr_fall_w  = ~pin_lvl[4] &  clr_prev_q;
    assign sync_lvl_w  =  pin_lvl[2];

    dac_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sync_fall  (sync_fall),
        .sync_rise  (sync_rise),
        .sdi        (pin_lvl[1]),
        .exec_o     (exec_w),
        .frame_o    (frame_w),
        .tx_start_o (tx_start),
        .tx_sel_o   (tx_sel),
        .tx_shift_o (tx_shift),
        .tx_stop_o  (tx_stop)
    );

    dac_chan_bank #(
        .NUM (NUM_CH)
    ) u_bank (
        .clk          (clk),
        .rst          (rst),
        .exec_i       (exec_w),
        .frame_i      (frame_w),
        .ldac_n_lvl   (pin_lvl[3]),
        .ldac_fall    (ldac_fall_w),
        .clr_n_lvl    (pin_lvl[4]),
        .clr_fall     (clr_fall_w),
        .rd_sel_i     (tx_sel),
        .ctrl_rdata_i (ctrl_rdata_i),
        .rd_data_o    (rd_data),
        .dac_codes_o  (dac_codes_o),
        .ctrl_wr_o    (ctrl_wr_o),
        .ctrl_wdata_o (ctrl_wdata_o)
    );

    dac_sdo_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .start_i  (tx_start),
        .shift_i  (tx_shift),
        .stop_i   (tx_stop),
        .load_i   (rd_data),
        .sdo_o    (sdo_o),
        .sdo_en_o (sdo_en_o)
    );

endmodule

// File: rtl/dac_if_chk.sv
module dac_if_chk
    import dac_if_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     exec,
    input logic                     ldac_fall,
    input logic                     clr_fall,
    input logic                     sync_lvl,
    input logic                     sdo_en,
    input logic                     ctrl_wr,
    input logic [NUM_CH*CODE_W-1:0] dac_codes
);

    // R5: control strobe lasts one cycle
    a_r5_ctrl_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !ctrl_wr);

    // R8: clear edge zeroes every output code on the next cycle
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr_fall |=> (dac_codes == '0));

    // R9: readback drive only starts inside a selected frame
    a_r9_drive_in_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> !sync_lvl);

    // R12: output codes hold unless a write, load edge or clear edge occurs
    a_r12_codes_hold: assert property (@(posedge clk) disable iff (rst)
        !(exec || ldac_fall || clr_fall) |=> $stable(dac_codes));

endmodule

bind quad_dac_serial_if dac_if_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .exec      (exec_w),
    .ldac_fall (ldac_fall_w),
    .clr_fall  (clr_fall_w),
    .sync_lvl  (sync_lvl_w),
    .sdo_en    (sdo_en_o),
    .ctrl_wr   (ctrl_wr_o),
    .dac_codes (dac_codes_o)
);

// File: tb/sim_quad_dac_serial_if.sv
module sim_quad_dac_serial_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [11:0] ctrl_rdata = 12'hA5C;
    logic        sdo, sdo_en, ctrl_wr;
    logic [47:0] dac_codes;
    logic [11:0] ctrl_wdata;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_in  [4];
    logic [11:0] m_dac [4];
    int          strobe_cnt = 0;
    int          strobe_exp = 0;
    logic [11:0] strobe_data = '0;
    logic [11:0] strobe_data_exp = '0;
    logic [11:0] rb;
    logic        early_en;

    always #5 clk = ~clk;

    quad_dac_serial_if u0 (
        .clk          (clk),
        .rst          (rst),
        .sync_n_i     (sync_n),
        .sclk_i       (sclk),
        .sdi_i        (sdi),
        .ldac_n_i     (ldac_n),
        .clr_n_i      (clr_n),
        .ctrl_rdata_i (ctrl_rdata),
        .sdo_o        (sdo),
        .sdo_en_o     (sdo_en),
        .dac_codes_o  (dac_codes),
        .ctrl_wr_o    (ctrl_wr),
        .ctrl_wdata_o (ctrl_wdata)
    );

    always @(posedge clk) begin
        if (!rst && ctrl_wr) begin
            strobe_cnt  <= strobe_cnt + 1;
            strobe_data <= ctrl_wdata;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_dacs(input string tag);
        for (int c = 0; c < 4; c++)
            chk(dac_codes[c*12 +: 12] === m_dac[c], tag, 48'(dac_codes[c*12 +: 12]), 48'(m_dac[c]));
    endtask

    function automatic logic [11:0] exp_rd(input logic [2:0] a);
        if (a >= 3'd1 && a <= 3'd4) return m_in[int'(a) - 1];
        if (a == 3'd7) return ctrl_rdata;
        return 12'h000;
    endfunction

    // Model of one executed frame (R1, R3, R4, R5, R7)
    task automatic model_exec(input logic [15:0] w);
        logic [2:0] a;
        a = w[14:12];
        if (w[15]) return;
        for (int c = 0; c < 4; c++) begin
            if (a == 3'(c + 1) || a == 3'd5) begin
                m_in[c] = w[11:0];
                if (!ldac_n) m_dac[c] = w[11:0];
            end
        end
        if (a == 3'd7) begin
            strobe_exp++;
            strobe_data_exp = w[11:0];
        end
    endtask

    // Sends nrise bits; complete=0 raises frame select before the last falling edge.
    task automatic send(input logic [15:0] w, input int nrise, input bit complete);
        early_en = 1'b0;
        rb = '0;
        sync_n = 1'b0;
        wclk(4);
        for (int i = 0; i < nrise; i++) begin
            sclk = 1'b0;
            sdi  = w[15-i];
            wclk(4);
            sclk = 1'b1;
            wclk(4);
            if (i < 4) early_en |= sdo_en;
            else       rb[15-i] = sdo;
        end
        if (complete) begin
            sclk = 1'b0;
            wclk(4);
        end
        sync_n = 1'b1;
        wclk(4);
        sclk = 1'b0;
        wclk(10);
        if (complete) model_exec(w);
    endtask

    task automatic ldac_pulse();
        ldac_n = 1'b0;
        wclk(6);
        if (clr_n) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
        ldac_n = 1'b1;
        wclk(6);
    endtask

    task automatic clr_pulse();
        clr_n = 1'b0;
        wclk(6);
        for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
        clr_n = 1'b1;
        wclk(6);
    endtask

    task automatic read_chk(input logic [2:0] a, input string tag);
        send({1'b1, a, 12'hFFF}, 16, 1'b1);
        chk(rb === exp_rd(a), tag, 48'(rb), 48'(exp_rd(a)));
        chk(!early_en, {tag, " early drive"}, 48'(early_en), 48'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
        wclk(5);
        rst = 1'b0;
        wclk(5);

        // R11: reset state
        chk_dacs("R11 reset codes");
        chk(sdo_en === 1'b0, "R11 sdo_en", 48'(sdo_en), 48'd0);
        chk(ctrl_wr === 1'b0, "R11 ctrl_wr", 48'(ctrl_wr), 48'd0);

        // R1: write channel 2 with load high, outputs hold
        send({1'b0, 3'd3, 12'h3C7}, 16, 1'b1);
        chk_dacs("R1 hold outputs");
        read_chk(3'd3, "R1/R10 readback ch2");

        // R6: load edge copies all
        send({1'b0, 3'd1, 12'h111}, 16, 1'b1);
        ldac_pulse();
        chk_dacs("R6 load copy");

        // R7: load held low, addressed channel updates at once
        ldac_n = 1'b0;
        wclk(6);
        for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
        send({1'b0, 3'd4, 12'h9E2}, 16, 1'b1);
        chk_dacs("R7 auto update");
        ldac_n = 1'b1;
        wclk(6);

        // R3: broadcast
        send({1'b0, 3'd5, 12'h5A5}, 16, 1'b1);
        for (int a = 1; a <= 4; a++) read_chk(3'(a), "R3 broadcast readback");
        chk_dacs("R3 outputs held");

        // R4: no-op and reserved
        send({1'b0, 3'd0, 12'hBAD}, 16, 1'b1);
        send({1'b0, 3'd6, 12'hBAD}, 16, 1'b1);
        for (int a = 1; a <= 4; a++) read_chk(3'(a), "R4 no change");
        chk(strobe_cnt == 0, "R4 no strobe", 48'(strobe_cnt), 48'd0);

        // R5: control write strobe
        send({1'b0, 3'd7, 12'h6D3}, 16, 1'b1);
        chk(strobe_cnt == 1, "R5 strobe count", 48'(strobe_cnt), 48'd1);
        chk(strobe_data === 12'h6D3, "R5 strobe data", 48'(strobe_data), 48'h6D3);

        // R10: control, no-op, broadcast, reserved reads
        read_chk(3'd7, "R10 ctrl read");
        read_chk(3'd0, "R10 read addr0");
        read_chk(3'd5, "R10 read addr5");
        read_chk(3'd6, "R10 read addr6");

        // R2: aborts, short and after all 16 rising edges
        send({1'b0, 3'd1, 12'hEEE}, 9, 1'b0);
        chk(sdo_en === 1'b0, "R2 idle after abort", 48'(sdo_en), 48'd0);
        send({1'b0, 3'd1, 12'hEEE}, 16, 1'b0);
        read_chk(3'd1, "R2 abort no write");

        // R9: read aborted mid-stream releases the drive
        send({1'b1, 3'd2, 12'h000}, 9, 1'b0);
        chk(sdo_en === 1'b0, "R9 release on select rise", 48'(sdo_en), 48'd0);

        // R8: clear, then load edges ignored while clear low
        clr_n = 1'b0;
        wclk(6);
        for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
        chk_dacs("R8 cleared");
        send({1'b0, 3'd1, 12'h123}, 16, 1'b1);
        ldac_pulse();
        chk_dacs("R8 load ignored in clear");
        clr_n = 1'b1;
        wclk(6);
        ldac_pulse();
        chk(dac_codes[11:0] === 12'h123, "R8 load after clear", 48'(dac_codes[11:0]), 48'h123);

        // Random mix (R1 R3 R4 R5 R6 R7 R8 R10 R12)
        for (int it = 0; it < 80; it++) begin
            logic [15:0] w;
            int sel;
            w = 16'($urandom);
            sel = int'($urandom % 10);
            if (sel == 0) clr_pulse();
            else if (sel == 1) ldac_pulse();
            if ($urandom % 4 == 0) begin
                ldac_n = 1'b0;
                wclk(6);
                if (clr_n) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
            end
            if (w[15]) read_chk(w[14:12], "R10 random read");
            else       send(w, 16, 1'b1);
            ldac_n = 1'b1;
            wclk(6);
            chk_dacs("R12 random outputs");
        end
        chk(strobe_cnt == strobe_exp, "R5 random strobe count", 48'(strobe_cnt), 48'(strobe_exp));
        chk(strobe_data === strobe_data_exp, "R5 random strobe data", 48'(strobe_data), 48'(strobe_data_exp));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule